// File: doc/BRIEF.md
# Reset-Time Configuration Loader

This block runs once after the chip's fundamental reset is released. While reset is held it samples a set of strap pins: a 3-bit boot mode, four EEPROM address pins, a bus-speed strap and a halt strap. When reset is released it keeps those values for the rest of the session. In the load mode it reads an image of configuration records from a serial EEPROM, one byte at a time, through a simple request/acknowledge byte-read port that stands in for the bit-level serial bus master. Each complete record becomes one write into the configuration register file, so the values in the image replace the register reset defaults.

The image is a flat list of six-byte records: a 16-bit register address sent high byte first, then a 32-bit data word sent most significant byte first. A record whose address is 0xFFFF marks the end of the image. A refused byte (NACK) or a byte read that gets no answer within a bounded number of cycles stops the load and raises a sticky error flag. Bytes already collected for an unfinished record are dropped, so that register keeps its default. If the halt strap was high during reset, the block still completes its load but keeps the device held until software clears the halt bit. Only then does the done output rise and normal operation begin.

Top module: `cfg_boot_loader`

## Requirements
- R1: The mode, address pin and bus-speed straps are captured on the last clock edge of reset. After reset is released, `bus_slow` and `rd_dev` do not change, whatever the strap pins do. No input other than reset can change `bus_slow`.
- R2: With boot mode 0, no byte read is ever requested. If the device is not halted, `done` is high one clock edge after reset is released.
- R3: Boot modes 2 to 7 are reserved and behave exactly like mode 0: no reads, and `done` one edge after release.
- R4: With boot mode 1, reads go to the 7-bit device address {1,0,1,pins[3:0]}: address bits 7..5 are 1,0,1 and bits 4..1 are the four address pins. Byte offsets run 0,1,2,... with one request at a time. `rd_req` stays high until `rd_ack` or `rd_nack` is seen.
- R5: Every six bytes form one record: bytes 0-1 are the register address (high byte first) and bytes 2-5 the data word (most significant byte first). Each complete record produces exactly one `cfg_wr_en` pulse carrying that address and data.
- R6: A record whose address is 0xFFFF ends the load without a write. The block then reads nothing more.
- R7: A NACK aborts the load. `load_err` goes high and stays high until the next reset. The record that was being collected is not written. The load still counts as finished.
- R8: A request that gets neither ACK nor NACK is dropped after TIMEOUT_CYC cycles with `rd_req` high. The load then aborts as in R7.
- R9: If the halt strap was high during reset, `halted` is high and `done` stays low after the load finishes, until a `halt_clr` pulse clears the halt bit. `done` rises on the edge that samples `halt_clr`.
- R10: `done` is never high while a read is requested or a write is issued. Reset clears `load_err` and `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high fundamental reset; straps are sampled while it is high |
| strap_mode | input | 3 | Boot mode strap: 0 plain, 1 load from EEPROM, 2-7 reserved |
| strap_addr_pins | input | 4 | EEPROM address strap pins (device address bits 4..1) |
| strap_slow | input | 1 | Bus-speed strap: 1 selects the slow master bus rate |
| strap_halt | input | 1 | Halt strap: 1 keeps the device held after the load |
| halt_clr | input | 1 | Pulse from a software write that clears the halt bit |
| rd_req | output | 1 | Byte-read request to the serial bus master |
| rd_dev | output | 7 | Device address of the EEPROM |
| rd_offset | output | OFF_W | Byte offset to read |
| rd_ack | input | 1 | Read completed; `rd_data` is valid |
| rd_nack | input | 1 | Read refused by the bus |
| rd_data | input | 8 | Byte returned with `rd_ack` |
| cfg_wr_en | output | 1 | Write strobe into the configuration register file |
| cfg_wr_addr | output | 16 | Register address of the write |
| cfg_wr_data | output | 32 | Data of the write |
| bus_slow | output | 1 | Latched bus-speed selection for the bus master |
| halted | output | 1 | Halt bit |
| load_err | output | 1 | Sticky load-abort flag |
| done | output | 1 | Load finished and halt bit clear |

## Verification
The bench builds the loader with TIMEOUT_CYC set to 24 instead of several thousand. This lets a silent EEPROM trip the timeout path in a few dozen cycles, and the bench checks the exact length of the abandoned request. OFF_W keeps its default of 16. Images of up to six records fit in a small bench array, so random record counts (including an image that holds only the end marker) and random NACK positions reach every byte position inside a record. They also reach a NACK that lands on the end-marker record itself.

// File: rtl/cfg_boot_pkg.sv
package cfg_boot_pkg;

    localparam int MODE_W     = 3;
    localparam int PIN_W      = 4;
    localparam int DEV_W      = 7;
    localparam int REG_ADDR_W = 16;
    localparam int REG_DATA_W = 32;
    localparam int REC_BITS   = REG_ADDR_W + REG_DATA_W;
    localparam int REC_BYTES  = REC_BITS / 8;

    localparam logic [MODE_W-1:0]     MODE_LOAD = MODE_W'(1);
    localparam logic [REG_ADDR_W-1:0] END_MARK  = '1;

    // Straps kept after reset (the halt strap lives in its own bit).
    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [PIN_W-1:0]  pins;
        logic              slow;
    } straps_t;

    typedef struct packed {
        logic [REG_ADDR_W-1:0] addr;
        logic [REG_DATA_W-1:0] data;
    } cfg_rec_t;

    typedef enum logic [2:0] {
        ST_START,
        ST_ISSUE,
        ST_WAIT,
        ST_APPLY,
        ST_END
    } ld_state_t;

    // Only mode 1 loads; 0 and the reserved codes skip the load.
    function automatic logic wants_load(input logic [MODE_W-1:0] m);
        return m == MODE_LOAD;
    endfunction

    // Device address bits 7..1: fixed 1,0,1 above the four strap pins.
    function automatic logic [DEV_W-1:0] eeprom_dev(input logic [PIN_W-1:0] p);
        return {3'b101, p};
    endfunction

endpackage

// File: rtl/cbl_strap_latch.sv
module cbl_strap_latch
    import cfg_boot_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  straps_t straps_in,
    input  logic    halt_in,
    input  logic    halt_clr,
    output straps_t straps_q,
    output logic    halt_bit
);

    // Straps follow the pins while reset is high; the last reset edge keeps them.
    always_ff @(posedge clk) begin
        if (rst) begin
            straps_q <= straps_in;
            halt_bit <= halt_in;
        end else if (halt_clr) begin
            halt_bit <= 1'b0;
        end
    end

endmodule

// File: rtl/cbl_byte_fetch.sv
module cbl_byte_fetch #(
    parameter int TIMEOUT_CYC = 4000
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    input  logic rd_ack,
    input  logic rd_nack,
    output logic rd_req,
    output logic got,
    output logic bad
);

    localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT_CYC - 1);

    logic             busy;
    logic [CNT_W-1:0] waited;
    logic             expired;

    assign expired = (waited == LIMIT);
    assign rd_req  = busy;
    assign got     = busy & rd_ack & ~rd_nack;
    assign bad     = busy & (rd_nack | (~rd_ack & expired));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            waited <= '0;
        end else if (busy) begin
            if (got || bad) begin
                busy   <= 1'b0;
                waited <= '0;
            end else begin
                waited <= waited + 1'b1;
            end
        end else if (go) begin
            busy   <= 1'b1;
            waited <= '0;
        end
    end

endmodule

// File: rtl/cbl_record_asm.sv
module cbl_record_asm
    import cfg_boot_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       push,
    input  logic [7:0] byte_in,
    output cfg_rec_t   rec,
    output logic       last_byte
);

    localparam int CNT_W = $clog2(REC_BYTES + 1);

    logic [REC_BITS-1:0] sh;
    logic [CNT_W-1:0]    cnt;

    // First byte received ends up at the top: address high byte first.
    assign rec       = cfg_rec_t'(sh);
    assign last_byte = (cnt == CNT_W'(REC_BYTES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            sh  <= '0;
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (push) begin
            sh  <= {sh[REC_BITS-9:0], byte_in};
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/cfg_boot_loader.sv
module cfg_boot_loader
    import cfg_boot_pkg::*;
#(
    parameter int OFF_W       = 16,
    parameter int TIMEOUT_CYC = 4000
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [MODE_W-1:0]     strap_mode,
    input  logic [PIN_W-1:0]      strap_addr_pins,
    input  logic                  strap_slow,
    input  logic                  strap_halt,
    input  logic                  halt_clr,
    output logic                  rd_req,
    output logic [DEV_W-1:0]      rd_dev,
    output logic [OFF_W-1:0]      rd_offset,
    input  logic                  rd_ack,
    input  logic                  rd_nack,
    input  logic [7:0]            rd_data,
    output logic                  cfg_wr_en,
    output logic [REG_ADDR_W-1:0] cfg_wr_addr,
    output logic [REG_DATA_W-1:0] cfg_wr_data,
    output logic                  bus_slow,
    output logic                  halted,
    output logic                  load_err,
    output logic                  done
);

    straps_t   straps_in, straps_q;
    logic      halt_bit;
    ld_state_t st;
    logic      go, got, bad, push, clr, last_byte, is_end;
    cfg_rec_t  rec;

    assign straps_in = '{mode: strap_mode, pins: strap_addr_pins, slow: strap_slow};

    cbl_strap_latch u_straps (
        .clk      (clk),
        .rst      (rst),
        .straps_in(straps_in),
        .halt_in  (strap_halt),
        .halt_clr (halt_clr),
        .straps_q (straps_q),
        .halt_bit (halt_bit)
    );

    cbl_byte_fetch #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_fetch (
        .clk    (clk),
        .rst    (rst),
        .go     (go),
        .rd_ack (rd_ack),
        .rd_nack(rd_nack),
        .rd_req (rd_req),
        .got    (got),
        .bad    (bad)
    );

    cbl_record_asm u_asm (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .push     (push),
        .byte_in  (rd_data),
        .rec      (rec),
        .last_byte(last_byte)
    );

    assign go     = (st == ST_ISSUE);
    assign push   = (st == ST_WAIT) && got;
    assign clr    = (st == ST_APPLY);
    assign is_end = (rec.addr == END_MARK);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_START;
            rd_offset <= '0;
            load_err  <= 1'b0;
        end else begin
            unique case (st)
                ST_START: st <= wants_load(straps_q.mode) ? ST_ISSUE : ST_END;
                ST_ISSUE: st <= ST_WAIT;
                ST_WAIT: begin
                    if (got) begin
                        rd_offset <= rd_offset + 1'b1;
                        st        <= last_byte ? ST_APPLY : ST_ISSUE;
                    end else if (bad) begin
                        load_err <= 1'b1;
                        st       <= ST_END;
                    end
                end
                ST_APPLY: st <= is_end ? ST_END : ST_ISSUE;
                ST_END:   st <= ST_END;
                default:  st <= ST_START;
            endcase
        end
    end

    assign cfg_wr_en   = (st == ST_APPLY) && !is_end;
    assign cfg_wr_addr = rec.addr;
    assign cfg_wr_data = rec.data;
    assign rd_dev      = eeprom_dev(straps_q.pins);
    assign bus_slow    = straps_q.slow;
    assign halted      = halt_bit;
    assign done        = (st == ST_END) && !halt_bit;

endmodule

// File: rtl/cfg_boot_checker.sv
module cfg_boot_checker
    import cfg_boot_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  rd_req,
    input logic                  rd_ack,
    input logic                  rd_nack,
    input logic [DEV_W-1:0]      rd_dev,
    input logic                  cfg_wr_en,
    input logic [REG_ADDR_W-1:0] cfg_wr_addr,
    input logic                  bus_slow,
    input logic                  halted,
    input logic                  load_err,
    input logic                  done
);

    assert_dev_stable_R1: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(rd_dev));

    assert_slow_stable_R1: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(bus_slow));

    // R4: a request is only withdrawn after a response or on an abort.
    assert_req_held_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(rd_req) |-> ($past(rd_ack) || $past(rd_nack) || load_err));

    assert_no_end_write_R6: assert property (@(posedge clk) disable iff (rst)
        cfg_wr_en |-> (cfg_wr_addr != END_MARK));

    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        load_err |=> load_err);

    assert_done_unhalted_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> !halted);

    assert_done_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        done |-> (!rd_req && !cfg_wr_en));

    assert_done_holds_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

endmodule

bind cfg_boot_loader cfg_boot_checker chk_i (
    .clk        (clk),
    .rst        (rst),
    .rd_req     (rd_req),
    .rd_ack     (rd_ack),
    .rd_nack    (rd_nack),
    .rd_dev     (rd_dev),
    .cfg_wr_en  (cfg_wr_en),
    .cfg_wr_addr(cfg_wr_addr),
    .bus_slow   (bus_slow),
    .halted     (halted),
    .load_err   (load_err),
    .done       (done)
);

// File: tb/cfg_boot_loader_tb_top.sv
module cfg_boot_loader_tb_top;

    localparam int TO    = 24;
    localparam int OFF_W = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [2:0] strap_mode = '0;
    logic [3:0] strap_addr_pins = '0;
    logic strap_slow = 1'b0, strap_halt = 1'b0, halt_clr = 1'b0;
    logic rd_req, rd_ack = 1'b0, rd_nack = 1'b0;
    logic [7:0] rd_data = '0;
    logic [6:0] rd_dev;
    logic [OFF_W-1:0] rd_offset;
    logic cfg_wr_en, bus_slow, halted, load_err, done;
    logic [15:0] cfg_wr_addr;
    logic [31:0] cfg_wr_data;

    always #4 clk = ~clk;

    cfg_boot_loader #(.OFF_W(OFF_W), .TIMEOUT_CYC(TO)) dut_i (
        .clk(clk), .rst(rst), .strap_mode(strap_mode), .strap_addr_pins(strap_addr_pins),
        .strap_slow(strap_slow), .strap_halt(strap_halt), .halt_clr(halt_clr),
        .rd_req(rd_req), .rd_dev(rd_dev), .rd_offset(rd_offset), .rd_ack(rd_ack),
        .rd_nack(rd_nack), .rd_data(rd_data), .cfg_wr_en(cfg_wr_en),
        .cfg_wr_addr(cfg_wr_addr), .cfg_wr_data(cfg_wr_data), .bus_slow(bus_slow),
        .halted(halted), .load_err(load_err), .done(done)
    );

    int checks = 0, errors = 0;
    logic [7:0] img [0:127];
    logic [15:0] wlog_a [0:15];
    logic [31:0] wlog_d [0:15];
    int nw, req_count, exp_off, seq_bad, viol, run_len, last_len, wait_left;
    int fail_off = -1, fail_kind = 0;
    bit pending;
    logic [6:0] exp_dev;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int exp_writes(input int nrec, input int foff);
        if (foff < 0) return nrec;
        return (foff / 6 < nrec) ? foff / 6 : nrec;
    endfunction

    function automatic int exp_reads(input int nrec, input int foff);
        return (foff < 0) ? (nrec + 1) * 6 : foff + 1;
    endfunction

    function automatic logic [15:0] img_addr(input int r);
        return {img[r*6], img[r*6+1]};
    endfunction

    function automatic logic [31:0] img_data(input int r);
        return {img[r*6+2], img[r*6+3], img[r*6+4], img[r*6+5]};
    endfunction

    // EEPROM model and port monitor, all on the falling edge.
    always @(negedge clk) begin
        if (cfg_wr_en && nw < 16) begin
            wlog_a[nw] = cfg_wr_addr;
            wlog_d[nw] = cfg_wr_data;
            nw++;
        end
        if (done && (rd_req || cfg_wr_en)) viol++;
        if (rd_req) run_len++;
        else if (run_len > 0) begin
            last_len = run_len;
            run_len = 0;
        end
        if (rd_ack || rd_nack) begin
            rd_ack = 1'b0;
            rd_nack = 1'b0;
            pending = 1'b0;
        end else if (!rd_req) begin
            pending = 1'b0;
        end else begin
            if (!pending) begin
                pending = 1'b1;
                wait_left = $urandom_range(0, 3);
                req_count++;
                if (int'(rd_offset) != exp_off || rd_dev != exp_dev) seq_bad++;
                exp_off++;
            end
            if (!(fail_kind == 1 && int'(rd_offset) == fail_off)) begin
                if (wait_left == 0) begin
                    if (fail_kind == 0 && int'(rd_offset) == fail_off) rd_nack = 1'b1;
                    else begin
                        rd_ack = 1'b1;
                        rd_data = img[rd_offset[6:0]];
                    end
                end else wait_left--;
            end
        end
    end

    task automatic run_load(input logic [2:0] mode, input logic [3:0] pins, input bit slow,
                            input bit halt, input int nrec, input int foff, input int fkind,
                            input string tag);
        bit loads;
        logic [31:0] d;
        logic [15:0] a;
        bit same;
        int ew;
        strap_mode = mode; strap_addr_pins = pins; strap_slow = slow; strap_halt = halt;
        rst = 1'b1;
        @(negedge clk); @(negedge clk);
        chk(!done && !rd_req && !cfg_wr_en && !load_err, {tag, " R10 reset state"},
            {done, rd_req, cfg_wr_en, load_err}, 0);
        chk(bus_slow == slow && rd_dev == {3'b101, pins}, {tag, " R1 straps in reset"},
            {bus_slow, rd_dev}, {slow, 3'b101, pins});
        for (int r = 0; r < nrec; r++) begin
            a = 16'($urandom_range(0, 16'hFFFE));
            d = $urandom;
            {img[r*6], img[r*6+1]} = a;
            {img[r*6+2], img[r*6+3], img[r*6+4], img[r*6+5]} = d;
        end
        {img[nrec*6], img[nrec*6+1]} = 16'hFFFF;
        for (int k = 2; k < 6; k++) img[nrec*6+k] = 8'($urandom);
        fail_off = foff; fail_kind = fkind;
        nw = 0; req_count = 0; exp_off = 0; seq_bad = 0; viol = 0; run_len = 0; last_len = 0;
        pending = 1'b0; exp_dev = {3'b101, pins};
        loads = (mode == 3'd1);
        rst = 1'b0;
        // straps wiggle after release: must have no effect (R1)
        strap_addr_pins = ~pins; strap_slow = ~slow; strap_mode = 3'd1 ^ mode;
        if (!loads && !halt) begin
            @(negedge clk);
            chk(done == 1'b1, {tag, mode == 3'd0 ? " R2 done one edge after release" :
                " R3 reserved mode done one edge after release"}, done, 1);
            repeat (30) @(negedge clk);
        end else if (halt) begin
            repeat (1500) @(negedge clk);
            chk(done == 1'b0 && halted == 1'b1, {tag, " R9 held after load"}, {done, halted}, 1);
            halt_clr = 1'b1;
            @(negedge clk);
            halt_clr = 1'b0;
            chk(done == 1'b1 && halted == 1'b0, {tag, " R9 released by halt_clr"},
                {done, halted}, 2);
        end else begin
            for (int c = 0; c < 3000 && !done; c++) @(negedge clk);
            repeat (5) @(negedge clk);
        end
        chk(bus_slow == slow && rd_dev == {3'b101, pins}, {tag, " R1 straps held"},
            {bus_slow, rd_dev}, {slow, 3'b101, pins});
        ew = loads ? exp_writes(nrec, foff) : 0;
        chk(nw == ew, {tag, " R5 write count"}, nw, ew);
        same = 1'b1;
        for (int r = 0; r < ew && r < nw; r++)
            if (wlog_a[r] != img_addr(r) || wlog_d[r] != img_data(r)) same = 1'b0;
        chk(same, {tag, " R5 write contents"}, same, 1);
        chk(req_count == (loads ? exp_reads(nrec, foff) : 0), {tag, " R4 R6 read count"},
            req_count, loads ? exp_reads(nrec, foff) : 0);
        chk(seq_bad == 0, {tag, " R4 offsets and device address"}, seq_bad, 0);
        chk(load_err == (loads && foff >= 0), {tag, " R7 R8 error flag"}, load_err,
            (loads && foff >= 0));
        chk(done == 1'b1, {tag, " R10 done after load"}, done, 1);
        chk(viol == 0, {tag, " R10 done while busy"}, viol, 0);
        fail_off = -1;
        fail_kind = 0;
    endtask

    initial begin
        int n;
        int fo;
        void'($urandom(32'h5EED_0042));
        // directed: plain mode, slow strap, and reserved modes
        run_load(3'd0, 4'h3, 1'b1, 1'b0, 0, -1, 0, "mode0");
        for (int k = 0; k < 3; k++)
            run_load(3'($urandom_range(2, 7)), 4'($urandom), 1'($urandom), 1'b0, 0, -1, 0,
                     "reserved");
        run_load(3'd7, 4'hA, 1'b0, 1'b0, 0, -1, 0, "reserved7");
        // empty image: only the end marker (R6)
        run_load(3'd1, 4'h0, 1'b0, 1'b0, 0, -1, 0, "empty R6");
        // random good images
        for (int k = 0; k < 5; k++)
            run_load(3'd1, 4'($urandom), 1'($urandom), 1'b0, $urandom_range(1, 6), -1, 0,
                     "load");
        // NACK at random positions, then sticky flag (R7)
        for (int k = 0; k < 4; k++) begin
            n = $urandom_range(1, 5);
            fo = $urandom_range(0, (n + 1) * 6 - 1);
            run_load(3'd1, 4'($urandom), 1'b0, 1'b0, n, fo, 0, "nack");
            repeat (20) @(negedge clk);
            chk(load_err == 1'b1, "nack R7 flag sticky", load_err, 1);
        end
        // NACK on the last byte of the second record
        run_load(3'd1, 4'h5, 1'b0, 1'b0, 3, 11, 0, "nack last byte R7");
        // timeout (R8)
        run_load(3'd1, 4'h9, 1'b1, 1'b0, 3, 8, 1, "timeout");
        chk(last_len == TO, "R8 request length before drop", last_len, TO);
        // halt with and without a load (R9)
        run_load(3'd1, 4'hC, 1'b0, 1'b1, 3, -1, 0, "halt load");
        run_load(3'd0, 4'h1, 1'b0, 1'b1, 0, -1, 0, "halt plain");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(150000 * 8);
        checks++;
        errors++;
        $display("FAIL watchdog expired R10 actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule